// File: doc/BRIEF.md
# UART Receive FIFO with Character Timeout

This block is the receive-side buffer of a 16550-style serial port. A receiver in front of it hands over complete bytes and break events. The block stores them in a 16-entry first-in first-out queue and serves reads of the receive buffer one byte at a time. It reports a data-ready flag, a break flag, an overrun flag and a trigger flag. The trigger flag rises when the fill level reaches the level that software has programmed.

The block also holds the FIFO control register. A write to that register can switch queueing on or off, flush the receive queue, ask for a transmit-queue flush, and pick the trigger level. With queueing off, the block falls back to a single holding register. The block works out how long one character takes on the line, counted in baud ticks, from the frame-format bits of the line control register. It uses that length to raise a timeout once data has sat unread for four character times.

Top module: `rxf_top`

## Requirements
- R1: In FIFO mode the queue holds up to 16 bytes and returns them in arrival order. `rd_data` shows the oldest byte, or 0x00 when the queue is empty. `fill_level` gives the count, and each `rd_pop` on a non-empty queue removes one byte.
- R2: Control bits 7:6 set the trigger level: 00 is 1 byte, 01 is 4, 10 is 8 and 11 is 14. In FIFO mode, `trig_hit` is high exactly when `fill_level` is at or above the selected level.
- R3: A byte or break that arrives while the queue holds 16 bytes, with no read in the same cycle, is discarded. The level stays at 16 and the sticky `overrun` flag is set.
- R4: A control write stores only bits 7, 6, 3 and 0 (mask 0xC9), and this stored value appears on `fcr_value`. Bit 0 selects FIFO mode. Reset leaves the register at 0x00, which is FIFO mode off.
- R5: A control write with bit 1 set empties the receive side: level 0, no data ready, and break, overrun and pending timeout all cleared. A write with bit 2 set raises `tx_fifo_clr` for exactly one cycle, in the cycle after the write, and does not touch the receive side.
- R6: A control write that changes bit 0 acts as if bits 1 and 2 were both set, whatever their actual values.
- R7: `char_ticks` equals 16 × (1 + data bits + parity bit + stop bits). Here data bits = `frame_fmt[1:0]` + 5, `frame_fmt[3]` adds one parity bit, and `frame_fmt[2]` selects two stop bits instead of one.
- R8: In FIFO mode, each received byte restarts a timer of 4 × `char_ticks` baud ticks. When the last tick of that window arrives with no read in between and data still queued, `timeout_pend` is set.
- R9: A read in FIFO mode clears `timeout_pend`. It restarts the timeout window if bytes remain; if the queue became empty, no timeout follows.
- R10: A break event queues a 0x00 byte and sets both `break_seen` and `data_ready`. In FIFO mode, `break_seen` clears when a read empties the queue.
- R11: With FIFO mode off, a single holding register takes each byte. A read clears `data_ready` and `break_seen`. A byte that arrives while the holding register is still unread overwrites it and sets `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One pulse per baud tick (16 per bit) |
| frame_fmt | input | 4 | Frame format: [1:0] data length, [2] two stop bits, [3] parity on |
| fcr_wr | input | 1 | Write strobe for the FIFO control register |
| fcr_wdata | input | 8 | Control register write value |
| rx_push | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break event; queues 0x00 |
| rd_pop | input | 1 | Read of the receive buffer |
| rd_data | output | 8 | Byte presented to the reader |
| fifo_on | output | 1 | FIFO mode active |
| fcr_value | output | 8 | Stored control register bits |
| fill_level | output | 5 | Bytes held in the queue |
| data_ready | output | 1 | At least one unread byte |
| break_seen | output | 1 | Break received and not yet consumed |
| trig_hit | output | 1 | Fill level at or above the trigger level |
| timeout_pend | output | 1 | Character timeout pending |
| overrun | output | 1 | A byte was lost |
| tx_fifo_clr | output | 1 | One-cycle request to flush the transmit queue |
| char_ticks | output | 8 | Baud ticks in one character |

## Verification
The frame-format input is swept over all sixteen values. This separates each field's effect on the character length. The queue is filled one byte past full under each of the four trigger codes. Checking `trig_hit` and `overrun` after every single push pins down the exact threshold and the drop point, and reading back a per-code byte pattern shows the order is kept. The timeout is measured at one tick before and exactly at the window's end, for the shortest and longest frames. The same is done after a read that leaves bytes behind, which separates a restart from a stale expiry. Control writes that flush, toggle the mode or only request a transmit flush are each followed by a look at the fill level, to tell them apart.

// File: rtl/rxf_pkg.sv
// Package: shared types and helpers for the receive FIFO block.
// Assumes the trigger code is the two top bits of the control register.
package rxf_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_QUARTER  = 2'b01,
        TRIG_HALF     = 2'b10,
        TRIG_NEARFULL = 2'b11
    } trig_sel_e;

    // Bits of the control register that persist after a write.
    localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;

    // Map a trigger code onto a byte threshold.
    function automatic logic [7:0] trig_bytes(input trig_sel_e sel);
        case (sel)
            TRIG_ONE:      trig_bytes = 8'd1;
            TRIG_QUARTER:  trig_bytes = 8'd4;
            TRIG_HALF:     trig_bytes = 8'd8;
            default:       trig_bytes = 8'd14;
        endcase
    endfunction

endpackage

// File: rtl/rxf_ctrl.sv
// Module: FIFO control register.
// Stores the persistent bits, decodes the trigger level and produces
// flush requests. A change of the enable bit forces both flushes.
// The receive flush acts on the same edge as the write; the transmit
// request is a registered one-cycle pulse.
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fcr_wr,
    input  logic [7:0]       fcr_wdata,
    output logic [7:0]       fcr_q,
    output logic             rx_flush,
    output logic             tx_pulse,
    output logic [CNT_W-1:0] trig_level
);

    logic mode_flip;
    logic tx_flush_d;
    logic [7:0] trig_full;

    // Purpose: detect requests carried by the current write.
    always_comb begin
        mode_flip  = fcr_wr && (fcr_wdata[0] != fcr_q[0]);
        rx_flush   = (fcr_wr && fcr_wdata[1]) || mode_flip;
        tx_flush_d = (fcr_wr && fcr_wdata[2]) || mode_flip;
        trig_full  = trig_bytes(trig_sel_e'(fcr_q[7:6]));
        trig_level = trig_full[CNT_W-1:0];
    end

    // Purpose: hold the persistent control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcr_q <= 8'h00;
        end else if (fcr_wr) begin
            fcr_q <= fcr_wdata & FCR_KEEP_MASK;
        end
    end

    // Purpose: register the one-cycle transmit flush request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_pulse <= 1'b0;
        end else begin
            tx_pulse <= tx_flush_d;
        end
    end

endmodule

// File: rtl/rxf_store.sv
// Module: receive byte storage.
// In FIFO mode a circular queue of DEPTH entries; otherwise a single
// holding register. Tracks break and overrun. A flush beats every
// other action on the same edge. Assumes DEPTH is a power of two.
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       fifo_mode,
    input  logic                       push,
    input  logic                       push_brk,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    output logic [DW-1:0]              head_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       data_ready,
    output logic                       brk_flag,
    output logic                       ovr_flag
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [DW-1:0]    hold_q;
    logic             hold_v;
    logic             pop_ok, wr_ok, is_full;
    logic [DW-1:0]    in_byte;

    // Purpose: decide which queue operations take effect this cycle.
    always_comb begin
        in_byte = push_brk ? '0 : push_data;
        is_full = (level == CNT_W'(DEPTH));
        pop_ok  = fifo_mode && pop && (level != '0);
        wr_ok   = fifo_mode && (push || push_brk) && (!is_full || pop_ok);
    end

    // Purpose: write accepted bytes into the queue storage.
    always_ff @(posedge clk) begin
        if (wr_ok && !flush) begin
            mem[wr_ptr] <= in_byte;
        end
    end

    // Purpose: pointers, level, holding register and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            hold_q   <= '0;
            hold_v   <= 1'b0;
            brk_flag <= 1'b0;
            ovr_flag <= 1'b0;
        end else if (fifo_mode) begin
            if (wr_ok)  wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
            level <= level + CNT_W'(wr_ok) - CNT_W'(pop_ok);
            if ((push || push_brk) && !wr_ok) ovr_flag <= 1'b1;
            if (push_brk) begin
                brk_flag <= 1'b1;
            end else if (pop_ok && level == CNT_W'(1) && !wr_ok) begin
                brk_flag <= 1'b0;
            end
        end else begin
            if (push || push_brk) begin
                hold_q   <= in_byte;
                hold_v   <= 1'b1;
                brk_flag <= push_brk || (brk_flag && !pop);
                if (hold_v && !pop) ovr_flag <= 1'b1;
            end else if (pop) begin
                hold_v   <= 1'b0;
                brk_flag <= 1'b0;
            end
        end
    end

    // Purpose: present the byte a read would return, and data-ready.
    always_comb begin
        if (fifo_mode) begin
            head_data  = (level == '0) ? '0 : mem[rd_ptr];
            data_ready = (level != '0);
        end else begin
            head_data  = hold_q;
            data_ready = hold_v;
        end
    end

endmodule

// File: rtl/rxf_timer.sv
// Module: character length and receive timeout.
// Character length is start + data + parity + stop bits times
// TICKS_PER_BIT. The timeout window is TIMEOUT_CHARS characters of
// baud ticks, restarted by each byte and by a read that leaves data.
// Inactive outside FIFO mode.
module rxf_timer #(
    parameter int TICKS_PER_BIT = 16,
    parameter int TIMEOUT_CHARS = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       flush,
    input  logic                                       fifo_mode,
    input  logic                                       baud_tick,
    input  logic [3:0]                                 frame_fmt,
    input  logic                                       push_evt,
    input  logic                                       pop_evt,
    input  logic                                       remain,
    input  logic                                       has_data,
    output logic [$clog2(TICKS_PER_BIT*13)-1:0]        char_ticks,
    output logic                                       pend
);

    localparam int CH_W  = $clog2(TICKS_PER_BIT*13);
    localparam int TMR_W = $clog2(TICKS_PER_BIT*13*TIMEOUT_CHARS);

    logic [3:0]       char_bits;
    logic [TMR_W-1:0] limit;
    logic [TMR_W-1:0] cnt;
    logic             armed;

    // Purpose: derive the frame length and the timeout window.
    always_comb begin
        char_bits  = 4'd6 + {2'b00, frame_fmt[1:0]} + {3'b000, frame_fmt[3]}
                   + (frame_fmt[2] ? 4'd2 : 4'd1);
        char_ticks = CH_W'(char_bits) * CH_W'(TICKS_PER_BIT);
        limit      = TMR_W'(char_ticks) * TMR_W'(TIMEOUT_CHARS);
    end

    // Purpose: run the timeout window and set the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || !fifo_mode) begin
            cnt   <= '0;
            armed <= 1'b0;
            pend  <= 1'b0;
        end else begin
            if (pop_evt) pend <= 1'b0;
            if (push_evt || (pop_evt && remain)) begin
                cnt   <= '0;
                armed <= 1'b1;
            end else if (pop_evt) begin
                armed <= 1'b0;
            end else if (armed && baud_tick) begin
                if (cnt == limit - 1'b1) begin
                    armed <= 1'b0;
                    pend  <= has_data;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rxf_top.sv
// Module: receive FIFO with control register and character timeout.
// Joins the control register, the byte store and the timeout timer.
// Assumes a receiver delivers at most one byte or break per cycle.
module rxf_top #(
    parameter int DEPTH         = 16,
    parameter int TICKS_PER_BIT = 16,
    parameter int TIMEOUT_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [3:0] frame_fmt,
    input  logic       fcr_wr,
    input  logic [7:0] fcr_wdata,
    input  logic       rx_push,
    input  logic [7:0] rx_byte,
    input  logic       rx_break,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       fifo_on,
    output logic [7:0] fcr_value,
    output logic [4:0] fill_level,
    output logic       data_ready,
    output logic       break_seen,
    output logic       trig_hit,
    output logic       timeout_pend,
    output logic       overrun,
    output logic       tx_fifo_clr,
    output logic [7:0] char_ticks
);

    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int CH_W  = $clog2(TICKS_PER_BIT*13);

    logic             rx_flush;
    logic [CNT_W-1:0] trig_level;
    logic [CNT_W-1:0] level;
    logic [CH_W-1:0]  ch_ticks;
    logic             dr_int;
    logic             pop_evt, push_evt, remain;

    rxf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fcr_wr     (fcr_wr),
        .fcr_wdata  (fcr_wdata),
        .fcr_q      (fcr_value),
        .rx_flush   (rx_flush),
        .tx_pulse   (tx_fifo_clr),
        .trig_level (trig_level)
    );

    rxf_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_flush),
        .fifo_mode  (fifo_on),
        .push       (rx_push),
        .push_brk   (rx_break),
        .push_data  (rx_byte),
        .pop        (rd_pop),
        .head_data  (rd_data),
        .level      (level),
        .data_ready (dr_int),
        .brk_flag   (break_seen),
        .ovr_flag   (overrun)
    );

    // Purpose: events seen by the timeout timer.
    always_comb begin
        fifo_on    = fcr_value[0];
        push_evt   = rx_push || rx_break;
        pop_evt    = rd_pop && (level != '0);
        remain     = (level > CNT_W'(1)) || push_evt;
        data_ready = dr_int;
        trig_hit   = fifo_on ? (level >= trig_level) : dr_int;
        fill_level = 5'(level);
        char_ticks = 8'(ch_ticks);
    end

    rxf_timer #(.TICKS_PER_BIT(TICKS_PER_BIT), .TIMEOUT_CHARS(TIMEOUT_CHARS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_flush),
        .fifo_mode  (fifo_on),
        .baud_tick  (baud_tick),
        .frame_fmt  (frame_fmt),
        .push_evt   (push_evt),
        .pop_evt    (pop_evt),
        .remain     (remain),
        .has_data   (level != '0),
        .char_ticks (ch_ticks),
        .pend       (timeout_pend)
    );

endmodule

// File: rtl/rxf_checker.sv
// Module: temporal properties of the receive FIFO, bound to the top.
module rxf_checker #(
    parameter int DEPTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fcr_wr,
    input logic [7:0] fcr_wdata,
    input logic       rx_push,
    input logic       rx_break,
    input logic       rd_pop,
    input logic       fifo_on,
    input logic [7:0] fcr_value,
    input logic [4:0] fill_level,
    input logic       data_ready,
    input logic       break_seen,
    input logic       timeout_pend,
    input logic       overrun
);

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= 5'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && fill_level == 5'(DEPTH) && (rx_push || rx_break) && !rd_pop && !fcr_wr
        |=> overrun && fill_level == 5'(DEPTH));

    p_fcr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr |=> fcr_value == ($past(fcr_wdata) & 8'hC9));

    p_rx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && fcr_wdata[1]
        |=> fill_level == 5'd0 && !timeout_pend && !overrun && !break_seen);

    p_mode_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && (fcr_wdata[0] != fcr_value[0]) |=> fill_level == 5'd0 && !data_ready);

    p_tmo_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pend |-> fill_level != 5'd0);

    p_read_clears_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && rd_pop && fill_level != 5'd0 && !fcr_wr |=> !timeout_pend);

    p_break_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break && !fcr_wr |=> break_seen && data_ready);

    p_hold_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on && rd_pop && !rx_push && !rx_break && !fcr_wr |=> !data_ready && !break_seen);

endmodule

bind rxf_top rxf_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_rxf_top.sv
module tb_rxf_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       baud_tick;
    logic [3:0] frame_fmt;
    logic       fcr_wr;
    logic [7:0] fcr_wdata;
    logic       rx_push;
    logic [7:0] rx_byte;
    logic       rx_break;
    logic       rd_pop;
    logic [7:0] rd_data;
    logic       fifo_on;
    logic [7:0] fcr_value;
    logic [4:0] fill_level;
    logic       data_ready, break_seen, trig_hit, timeout_pend, overrun, tx_fifo_clr;
    logic [7:0] char_ticks;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxf_top dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_byte(input logic [7:0] b);
        rx_push = 1'b1; rx_byte = b; step(); rx_push = 1'b0;
    endtask

    task automatic push_brk();
        rx_break = 1'b1; step(); rx_break = 1'b0;
    endtask

    task automatic pop();
        rd_pop = 1'b1; step(); rd_pop = 1'b0;
    endtask

    task automatic fcr_write(input logic [7:0] v);
        fcr_wr = 1'b1; fcr_wdata = v; step(); fcr_wr = 1'b0;
    endtask

    function automatic int exp_ticks(input logic [3:0] f);
        return 16 * (1 + (int'(f[1:0]) + 5) + int'(f[3]) + (f[2] ? 2 : 1));
    endfunction

    function automatic logic [7:0] pat(input int code, input int n);
        return 8'((code * 53 + n * 37 + 5) & 255);
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int lim;
        int tl;
        rst_n = 1'b0; baud_tick = 1'b0; frame_fmt = 4'h0; fcr_wr = 1'b0; fcr_wdata = 8'h00;
        rx_push = 1'b0; rx_byte = 8'h00; rx_break = 1'b0; rd_pop = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // Reset state (R4, R1)
        chk("R4 reset fcr", fcr_value, 8'h00);
        chk("R4 reset mode", fifo_on, 1'b0);
        chk("R1 reset level", fill_level, 5'd0);
        chk("R1 reset ready", data_ready, 1'b0);
        chk("R8 reset timeout", timeout_pend, 1'b0);
        chk("R3 reset overrun", overrun, 1'b0);

        // R7: exhaustive frame-format sweep
        for (int f = 0; f < 16; f++) begin
            frame_fmt = 4'(f);
            #1;
            chk("R7 char ticks", char_ticks, 32'(exp_ticks(4'(f))));
        end
        frame_fmt = 4'h0;

        // R11: holding-register mode
        push_byte(8'hA5);
        chk("R11 ready", data_ready, 1'b1);
        chk("R11 data", rd_data, 8'hA5);
        chk("R11 no overrun yet", overrun, 1'b0);
        push_byte(8'h3C);
        chk("R11 overwrite data", rd_data, 8'h3C);
        chk("R11 overrun", overrun, 1'b1);
        pop();
        chk("R11 read clears ready", data_ready, 1'b0);
        push_brk();
        chk("R11 break flag", break_seen, 1'b1);
        chk("R11 break byte", rd_data, 8'h00);
        pop();
        chk("R11 read clears break", break_seen, 1'b0);
        chk("R11 read clears ready after break", data_ready, 1'b0);

        // R4/R6: enable via write of all ones
        fcr_write(8'hFF);
        chk("R4 stored mask", fcr_value, 8'hC9);
        chk("R6 tx flush pulse", tx_fifo_clr, 1'b1);
        chk("R6 overrun cleared", overrun, 1'b0);
        step();
        chk("R5 tx pulse one cycle", tx_fifo_clr, 1'b0);

        // R1/R2/R3: trigger sweep per code, fill past full, drain
        for (int code = 0; code < 4; code++) begin
            tl = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
            fcr_write(8'((code << 6) | 3));
            chk("R2 empty no trigger", trig_hit, 1'b0);
            for (int n = 1; n <= 17; n++) begin
                push_byte(pat(code, n));
                chk("R1 level", fill_level, 32'((n > 16) ? 16 : n));
                chk("R2 trigger", trig_hit, 32'(((n > 16 ? 16 : n) >= tl) ? 1 : 0));
                chk("R3 overrun", overrun, 32'((n > 16) ? 1 : 0));
            end
            for (int n = 1; n <= 16; n++) begin
                chk("R1 order", rd_data, pat(code, n));
                pop();
                chk("R1 drain level", fill_level, 32'(16 - n));
            end
            chk("R1 empty ready", data_ready, 1'b0);
            chk("R1 empty data", rd_data, 8'h00);
        end

        // R5: tx-only flush leaves receive side; rx flush empties
        chk("R5 overrun sticky", overrun, 1'b1);
        push_byte(8'h01); push_byte(8'h02); push_byte(8'h03);
        fcr_write(8'h05);
        chk("R5 tx flush pulse", tx_fifo_clr, 1'b1);
        chk("R5 rx untouched", fill_level, 5'd3);
        fcr_write(8'h03);
        chk("R5 rx flushed", fill_level, 5'd0);
        chk("R5 overrun cleared", overrun, 1'b0);
        chk("R5 no tx pulse", tx_fifo_clr, 1'b0);

        // R6: toggling enable without reset bits
        push_byte(8'h44); push_byte(8'h55);
        fcr_write(8'h00);
        chk("R6 level flushed", fill_level, 5'd0);
        chk("R6 tx pulse", tx_fifo_clr, 1'b1);
        chk("R6 mode off", fifo_on, 1'b0);
        fcr_write(8'h01);
        chk("R6 mode on", fifo_on, 1'b1);

        // R10: break in FIFO mode
        push_byte(8'h11);
        push_brk();
        chk("R10 level", fill_level, 5'd2);
        chk("R10 break flag", break_seen, 1'b1);
        chk("R10 first data", rd_data, 8'h11);
        pop();
        chk("R10 break kept", break_seen, 1'b1);
        chk("R10 zero byte", rd_data, 8'h00);
        pop();
        chk("R10 break cleared", break_seen, 1'b0);
        chk("R10 ready cleared", data_ready, 1'b0);

        // R8: timeout window for shortest and longest frames
        for (int k = 0; k < 2; k++) begin
            frame_fmt = (k == 0) ? 4'h0 : 4'hF;
            lim = 4 * exp_ticks(frame_fmt);
            fcr_write(8'h03);
            baud_tick = 1'b1;
            push_byte(8'h77);
            repeat (lim - 1) step();
            chk("R8 not yet", timeout_pend, 1'b0);
            step();
            chk("R8 pending", timeout_pend, 1'b1);
            pop();
            chk("R9 read clears", timeout_pend, 1'b0);
            repeat (lim + 5) step();
            chk("R9 no timeout when empty", timeout_pend, 1'b0);
            baud_tick = 1'b0;
        end

        // R9: read with bytes left restarts the window
        frame_fmt = 4'h0;
        lim = 4 * exp_ticks(4'h0);
        baud_tick = 1'b1;
        push_byte(8'hA1); push_byte(8'hA2);
        repeat (lim - 10) step();
        pop();
        chk("R9 cleared at read", timeout_pend, 1'b0);
        repeat (lim - 1) step();
        chk("R9 restarted window not expired", timeout_pend, 1'b0);
        step();
        chk("R9 restarted window expires", timeout_pend, 1'b1);
        baud_tick = 1'b0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule